// File: doc/BRIEF.md
# Exception Vectoring Controller

This block handles the way a simple 32-bit core enters and leaves its exception handlers. Each cycle it looks at two level-sensitive interrupt lines (a normal one and a fast one) and at five trap requests: reset, undefined instruction, supervisor call, prefetch abort and data abort. It also reads the core's current program counter and status word. When it accepts a request, it does three things in the same cycle. It drives the vector address and a new status word back to the core with matching load strobes. It records the return address in a link register that belongs to the target mode. It records the old status word in a saved-status register that also belongs to that mode.

A return request brings back the link value and the saved status of the current mode together, so the core never sees one of them updated without the other. The block also keeps one stack-pointer copy for each exception mode, plus one copy shared by user and system modes. The current mode field selects which copy is read and written. The general register file and the handler code sit outside this block.

Status word layout used throughout: bits [4:0] hold the mode, bit 7 masks the normal interrupt when set, and bit 6 masks the fast interrupt when set. The mode codes are:

| Mode | Code |
|------|------|
| user | 0x10 |
| fast interrupt | 0x11 |
| normal interrupt | 0x12 |
| supervisor | 0x13 |
| abort | 0x17 |
| undefined | 0x1B |
| system | 0x1F |

Top module: `exc_vector_unit`

## Requirements
- R1: When an exception is accepted, at the next clock edge the link register of the target mode receives pcIn plus an offset that depends on the exception type, modulo 2^32. The offsets are: reset +0, undefined +4, supervisor call +4, prefetch abort +4, data abort +8, normal interrupt +4, fast interrupt +4.
- R2: When an exception is accepted, at the next clock edge the saved-status register of the target mode receives statusIn unchanged.
- R3: In the same cycle as an accepted request, pcLoad and statusLoad are both 1 and pcOut carries the vector. The vectors are: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. When nothing is accepted and no return is performed, both loads are 0, pcOut equals pcIn and statusOut equals statusIn.
- R4: On entry, statusOut equals statusIn with three changes. Bits [4:0] become the target mode code: supervisor for reset and supervisor call, undefined for undefined, abort for both aborts, normal interrupt for the normal interrupt, fast interrupt for the fast interrupt. Bit 7 is set. Bit 6 is also set for the fast interrupt and for reset. All other bits pass through unchanged.
- R5: The normal interrupt line is ignored while statusIn bit 7 is 1. The fast interrupt line is ignored while statusIn bit 6 is 1.
- R6: Among the unmasked requests, the one served has the highest rank in this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, supervisor call.
- R7: When retReq is 1, no exception is accepted, and the current mode is one of the five exception modes, both loads are 1. pcOut shows that mode's link register and statusOut shows its saved status, in the same cycle. An accepted exception overrides a return in the same cycle.
- R8: A return request in user, system or any unrecognised mode has no effect: both loads stay 0.
- R9: spRdata shows the stack-pointer copy selected by the current mode. spWe=1 writes spWdata into that copy at the clock edge. User, system and unrecognised modes share one copy, and each exception mode has its own.
- R10: While rstN is 0, all link, saved-status and stack-pointer copies are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Normal interrupt, level-sensitive |
| fiqReq | input | 1 | Fast interrupt, level-sensitive |
| resetTrap | input | 1 | Reset exception request |
| undefTrap | input | 1 | Undefined instruction trap |
| svcTrap | input | 1 | Supervisor call trap |
| pabtTrap | input | 1 | Prefetch abort trap |
| dabtTrap | input | 1 | Data abort trap |
| retReq | input | 1 | Return from the current exception mode |
| pcIn | input | 32 | Current program counter |
| statusIn | input | 32 | Current status word |
| spWe | input | 1 | Write enable for the current mode's stack pointer |
| spWdata | input | 32 | Stack pointer write data |
| pcLoad | output | 1 | Core loads pcOut this cycle |
| pcOut | output | 32 | Vector or restored program counter |
| statusLoad | output | 1 | Core loads statusOut this cycle |
| statusOut | output | 32 | New or restored status word |
| spRdata | output | 32 | Stack pointer of the current mode |

## Verification
The assertions assume that every request and statusIn are stable around the clock edge. This matters because the entry decision is combinational, and the same inputs decide which bank is written at the edge. They also assume that rstN is low long enough for the banks to clear before any write-after-entry property is evaluated. The stimulus changes every input only just after the falling edge, keeps all requests low while reset is held, and applies combined request patterns only to test ranking and masking. A reference model keeps its own bank arrays and predicts the outputs of every cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MODE_W = 5;
  localparam int STAT_I = 7;
  localparam int STAT_F = 6;
  localparam int NBANK  = 5;
  localparam int BANK_W = $clog2(NBANK + 1);

  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

  typedef enum logic [2:0] {
    EX_RESET, EX_UNDEF, EX_SVC, EX_PABT, EX_DABT, EX_IRQ, EX_FIQ
  } excKind_e;

  typedef struct packed {
    logic     take;
    logic     ret;
    excKind_e kind;
  } ctrlStrb_t;

  function automatic logic [MODE_W-1:0] targetMode(excKind_e k);
    case (k)
      EX_UNDEF:        return M_UND;
      EX_PABT, EX_DABT: return M_ABT;
      EX_IRQ:          return M_IRQ;
      EX_FIQ:          return M_FIQ;
      default:         return M_SVC;
    endcase
  endfunction

  function automatic logic [7:0] vectorOf(excKind_e k);
    case (k)
      EX_UNDEF: return 8'h04;
      EX_SVC:   return 8'h08;
      EX_PABT:  return 8'h0C;
      EX_DABT:  return 8'h10;
      EX_IRQ:   return 8'h18;
      EX_FIQ:   return 8'h1C;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] linkOffset(excKind_e k);
    case (k)
      EX_RESET: return 4'd0;
      EX_DABT:  return 4'd8;
      default:  return 4'd4;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bankOf(logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BANK_W'(0);
      M_IRQ:   return BANK_W'(1);
      M_SVC:   return BANK_W'(2);
      M_ABT:   return BANK_W'(3);
      M_UND:   return BANK_W'(4);
      default: return BANK_W'(NBANK);
    endcase
  endfunction
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            irqReq,
  input  logic            fiqReq,
  input  logic            resetTrap,
  input  logic            undefTrap,
  input  logic            svcTrap,
  input  logic            pabtTrap,
  input  logic            dabtTrap,
  input  logic            retReq,
  input  logic [XLEN-1:0] statusIn,
  output ctrlStrb_t       strb
);
  logic irqOk, fiqOk, curBanked;

  assign irqOk     = irqReq && !statusIn[STAT_I];
  assign fiqOk     = fiqReq && !statusIn[STAT_F];
  assign curBanked = (bankOf(statusIn[MODE_W-1:0]) != BANK_W'(NBANK));

  always_comb begin
    strb = '{take: 1'b1, ret: 1'b0, kind: EX_RESET};
    if (resetTrap)      strb.kind = EX_RESET;
    else if (dabtTrap)  strb.kind = EX_DABT;
    else if (fiqOk)     strb.kind = EX_FIQ;
    else if (irqOk)     strb.kind = EX_IRQ;
    else if (pabtTrap)  strb.kind = EX_PABT;
    else if (undefTrap) strb.kind = EX_UNDEF;
    else if (svcTrap)   strb.kind = EX_SVC;
    else begin
      strb.take = 1'b0;
      strb.ret  = retReq && curBanked;
    end
  end

  // R6: an unmasked fast interrupt beats everything except reset and data abort
  assert_fiq_rank_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fiqReq && !statusIn[STAT_F] && !resetTrap && !dabtTrap)
      |-> (strb.take && strb.kind == EX_FIQ));

  // R5: a masked normal interrupt alone causes no entry
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && statusIn[STAT_I] && !fiqReq && !resetTrap && !dabtTrap &&
     !pabtTrap && !undefTrap && !svcTrap) |-> !strb.take);

  // R7: return and entry are never issued together
  assert_ret_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.take && strb.ret));
endmodule

// File: rtl/exc_dp.sv
module exc_dp
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] statusIn,
  input  logic            spWe,
  input  logic [XLEN-1:0] spWdata,
  output logic            pcLoad,
  output logic [XLEN-1:0] pcOut,
  output logic            statusLoad,
  output logic [XLEN-1:0] statusOut,
  output logic [XLEN-1:0] spRdata
);
  logic [XLEN-1:0] linkBank  [NBANK];
  logic [XLEN-1:0] savedBank [NBANK];
  logic [XLEN-1:0] spBank    [NBANK+1];

  logic [MODE_W-1:0] entryMode;
  logic [BANK_W-1:0] entryIdx, curIdx;
  logic [XLEN-1:0]   savePc;
  logic [NBANK-1:0]  bankHit;

  assign entryMode = targetMode(strb.kind);
  assign entryIdx  = bankOf(entryMode);
  assign curIdx    = bankOf(statusIn[MODE_W-1:0]);
  assign savePc    = pcIn + XLEN'(linkOffset(strb.kind));
  assign spRdata   = spBank[curIdx];

  for (genvar b = 0; b < NBANK; b++) begin : g_hit
    assign bankHit[b] = strb.take && (entryIdx == BANK_W'(b));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NBANK; i++) begin
        linkBank[i]  <= '0;
        savedBank[i] <= '0;
      end
      for (int i = 0; i <= NBANK; i++) spBank[i] <= '0;
    end else begin
      for (int i = 0; i < NBANK; i++) begin
        if (bankHit[i]) begin
          linkBank[i]  <= savePc;
          savedBank[i] <= statusIn;
        end
      end
      if (spWe) spBank[curIdx] <= spWdata;
    end
  end

  always_comb begin
    pcLoad     = 1'b0;
    statusLoad = 1'b0;
    pcOut      = pcIn;
    statusOut  = statusIn;
    if (strb.take) begin
      pcLoad                   = 1'b1;
      statusLoad               = 1'b1;
      pcOut                    = XLEN'(vectorOf(strb.kind));
      statusOut[MODE_W-1:0]    = entryMode;
      statusOut[STAT_I]        = 1'b1;
      if (strb.kind == EX_FIQ || strb.kind == EX_RESET)
        statusOut[STAT_F] = 1'b1;
    end else if (strb.ret) begin
      pcLoad     = 1'b1;
      statusLoad = 1'b1;
      pcOut      = linkBank[curIdx];
      statusOut  = savedBank[curIdx];
    end
  end

  // R7: PC and status are always loaded together
  assert_atomic_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad == statusLoad);

  // R3: every entry vector is word aligned and inside the table
  assert_vector_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> (pcOut[1:0] == 2'b00 && pcOut < XLEN'(32)));

  // R4: entry always masks the normal interrupt
  assert_entry_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> statusOut[STAT_I]);

  // R2: saved status of the target bank holds the pre-entry status word
  assert_saved_status_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> savedBank[$past(entryIdx)] == $past(statusIn));

  // R8: a return outside the exception modes produces no load
  assert_no_ret_unbanked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curIdx == BANK_W'(NBANK) && !strb.take) |-> !pcLoad);
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            irqReq,
  input  logic            fiqReq,
  input  logic            resetTrap,
  input  logic            undefTrap,
  input  logic            svcTrap,
  input  logic            pabtTrap,
  input  logic            dabtTrap,
  input  logic            retReq,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] statusIn,
  input  logic            spWe,
  input  logic [XLEN-1:0] spWdata,
  output logic            pcLoad,
  output logic [XLEN-1:0] pcOut,
  output logic            statusLoad,
  output logic [XLEN-1:0] statusOut,
  output logic [XLEN-1:0] spRdata
);
  ctrlStrb_t strb;

  exc_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .fiqReq(fiqReq),
    .resetTrap(resetTrap), .undefTrap(undefTrap), .svcTrap(svcTrap),
    .pabtTrap(pabtTrap), .dabtTrap(dabtTrap), .retReq(retReq),
    .statusIn(statusIn), .strb(strb)
  );

  exc_dp #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn), .statusIn(statusIn),
    .spWe(spWe), .spWdata(spWdata), .pcLoad(pcLoad), .pcOut(pcOut),
    .statusLoad(statusLoad), .statusOut(statusOut), .spRdata(spRdata)
  );
endmodule

// File: tb/sim_exc_vector_unit.sv
module sim_exc_vector_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReq = 0, fiqReq = 0, resetTrap = 0, undefTrap = 0, svcTrap = 0;
  logic pabtTrap = 0, dabtTrap = 0, retReq = 0, spWe = 0;
  logic [31:0] pcIn = '0, statusIn = 32'h10, spWdata = '0;
  logic pcLoad, statusLoad;
  logic [31:0] pcOut, statusOut, spRdata;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mLink [5];
  logic [31:0] mSaved[5];
  logic [31:0] mSp   [6];

  always #4 clk = ~clk;

  exc_vector_unit u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .fiqReq(fiqReq),
    .resetTrap(resetTrap), .undefTrap(undefTrap), .svcTrap(svcTrap),
    .pabtTrap(pabtTrap), .dabtTrap(dabtTrap), .retReq(retReq),
    .pcIn(pcIn), .statusIn(statusIn), .spWe(spWe), .spWdata(spWdata),
    .pcLoad(pcLoad), .pcOut(pcOut), .statusLoad(statusLoad),
    .statusOut(statusOut), .spRdata(spRdata)
  );

  function automatic int bankIdx(logic [4:0] m);
    if (m == 5'h11) return 0;
    if (m == 5'h12) return 1;
    if (m == 5'h13) return 2;
    if (m == 5'h17) return 3;
    if (m == 5'h1B) return 4;
    return 5;
  endfunction

  // 0 none, 1 reset, 2 undef, 3 svc, 4 pabt, 5 dabt, 6 irq, 7 fiq
  function automatic int pickKind();
    if (resetTrap) return 1;
    if (dabtTrap) return 5;
    if (fiqReq && !statusIn[6]) return 7;
    if (irqReq && !statusIn[7]) return 6;
    if (pabtTrap) return 4;
    if (undefTrap) return 2;
    if (svcTrap) return 3;
    return 0;
  endfunction

  task automatic clearModel();
    for (int i = 0; i < 5; i++) begin mLink[i] = '0; mSaved[i] = '0; end
    for (int i = 0; i < 6; i++) mSp[i] = '0;
  endtask

  task automatic cycle(input string tag);
    int k, cb, tb;
    logic eLoad;
    logic [31:0] ePc, eSt, eSp;
    logic [4:0] tmode;
    int vec[8] = '{0, 'h00, 'h04, 'h08, 'h0C, 'h10, 'h18, 'h1C};
    int off[8] = '{0, 0, 4, 4, 4, 8, 4, 4};
    #2;
    k  = pickKind();
    cb = bankIdx(statusIn[4:0]);
    eSp = mSp[cb];
    eLoad = 0; ePc = pcIn; eSt = statusIn; tb = 5;
    tmode = 5'h13;
    if (k != 0) begin
      case (k)
        2: tmode = 5'h1B;
        4, 5: tmode = 5'h17;
        6: tmode = 5'h12;
        7: tmode = 5'h11;
        default: tmode = 5'h13;
      endcase
      tb = bankIdx(tmode);
      eLoad = 1; ePc = vec[k];
      eSt = {statusIn[31:8], 1'b1, (k == 7 || k == 1) ? 1'b1 : statusIn[6],
             statusIn[5], tmode};
    end else if (retReq && cb != 5) begin
      eLoad = 1; ePc = mLink[cb]; eSt = mSaved[cb];
    end
    checks++;
    if (pcLoad !== eLoad || statusLoad !== eLoad || pcOut !== ePc ||
        statusOut !== eSt || spRdata !== eSp) begin
      errors++;
      $display("FAIL %s: load=%b/%b pc=%h st=%h sp=%h expected load=%b pc=%h st=%h sp=%h",
               tag, pcLoad, statusLoad, pcOut, statusOut, spRdata,
               eLoad, ePc, eSt, eSp);
    end
    @(posedge clk); #1;
    if (!rstN) clearModel();
    else begin
      if (k != 0) begin
        mLink[tb]  = pcIn + 32'(off[k]);
        mSaved[tb] = statusIn;
      end
      if (spWe) mSp[cb] = spWdata;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    irqReq = 0; fiqReq = 0; resetTrap = 0; undefTrap = 0; svcTrap = 0;
    pabtTrap = 0; dabtTrap = 0; retReq = 0; spWe = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes[7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    clearModel();
    for (int i = 0; i < 5; i++) begin mLink[i] = 'x; mSaved[i] = 'x; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    clearModel();
    cycle("R10");                                   // reset held, idle
    rstN = 1;
    statusIn = 32'h0000_0010; pcIn = 32'h1000;
    cycle("R3");                                    // idle passthrough
    // R10: banks start at zero; returns in each exception mode read zero
    retReq = 1;
    statusIn = 32'h13; cycle("R10");
    statusIn = 32'h11; cycle("R10");
    idle();
    // R9: stack pointer per mode
    foreach (modes[i]) begin
      statusIn = {27'h0, modes[i]}; spWe = 1; spWdata = 32'hA000 + 32'(i);
      cycle("R9");
    end
    spWe = 0;
    foreach (modes[i]) begin statusIn = {27'h0, modes[i]}; cycle("R9"); end
    // R1/R2/R3/R4: each exception type then return in its mode (R7)
    for (int k = 1; k <= 7; k++) begin
      idle();
      statusIn = 32'hF000_0A10 + 32'(k << 8); pcIn = 32'h2000 + 32'(k * 16);
      case (k)
        1: resetTrap = 1;
        2: undefTrap = 1;
        3: svcTrap = 1;
        4: pabtTrap = 1;
        5: dabtTrap = 1;
        6: irqReq = 1;
        default: fiqReq = 1;
      endcase
      cycle("R1");
      idle();
      retReq = 1;
      statusIn = (k == 2) ? 32'h1B : (k == 4 || k == 5) ? 32'h17 :
                 (k == 6) ? 32'h12 : (k == 7) ? 32'h11 : 32'h13;
      cycle("R7");
    end
    idle();
    // R4: other status bits preserved, F bit kept on normal interrupt
    statusIn = 32'h5A5A_5A50; pcIn = 32'hFFFF_FFFC; irqReq = 1;
    statusIn[7] = 0; cycle("R4");
    idle(); retReq = 1; statusIn = 32'h12; cycle("R1");  // wrapped link
    // R5: masking
    idle(); statusIn = 32'h90; irqReq = 1; cycle("R5");
    statusIn = 32'h50; irqReq = 0; fiqReq = 1; cycle("R5");
    statusIn = 32'hD0; irqReq = 1; cycle("R5");
    statusIn = 32'h50; cycle("R5");                 // fiq masked, irq taken
    // R6: ranking
    idle(); statusIn = 32'h10;
    resetTrap = 1; dabtTrap = 1; fiqReq = 1; irqReq = 1; pabtTrap = 1;
    undefTrap = 1; svcTrap = 1; cycle("R6");
    resetTrap = 0; cycle("R6");
    dabtTrap = 0; cycle("R6");
    fiqReq = 0; cycle("R6");
    irqReq = 0; cycle("R6");
    pabtTrap = 0; cycle("R6");
    undefTrap = 0; cycle("R6");
    // R7: entry overrides a return
    idle(); statusIn = 32'h13; retReq = 1; svcTrap = 1; pcIn = 32'h3000;
    cycle("R7");
    svcTrap = 0; cycle("R7");
    // R8: return ignored outside exception modes
    statusIn = 32'h10; cycle("R8");
    statusIn = 32'h1F; cycle("R8");
    statusIn = 32'h05; cycle("R8");
    // R10: reset mid-run clears banks
    idle(); rstN = 0; cycle("R10");
    rstN = 1; retReq = 1; statusIn = 32'h11; cycle("R10");
    statusIn = 32'h17; cycle("R10");
    idle(); statusIn = 32'h10; cycle("R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule